// File: doc/BRIEF.md
# Stack Push Decode and Execute Unit

This unit takes the first bytes of one stack-push instruction, works out its form, operand size and length, and produces everything the load/store path needs to carry it out: the decremented stack pointer, the store address, the right-aligned store data and a byte-enable mask. It covers four forms:
- push of a sign-extended byte immediate;
- push of a full-width immediate;
- push of a general register named in the opcode;
- push of a segment register.

It understands the operand-size prefix and, in 64-bit mode, the REX prefix.

Decoding and execution are combinational. The results are captured in output registers when an input is accepted on a valid/ready handshake, and held until the consumer takes them. Register operands come from an external register-file read port: the unit drives the index combinationally from the instruction bytes, and the data is expected back in the same cycle. When the buffer is too short, the unit raises a need-more-bytes flag. When the opcode is not legal, it raises an invalid-opcode flag. In both cases it leaves the stack pointer as it was.

Top module: `push_unit`

## Requirements
- R1: The `mode` input is encoded 0 = 16-bit, 1 = 32-bit, 2 = 64-bit; code 3 is reserved and yields the invalid-opcode flag. With no prefix, the push width is 2, 4 or 8 bytes respectively.
- R2: Byte 0x66, when it is the first byte, sets the width to 4 in 16-bit mode and to 2 in 32-bit or 64-bit mode. In 64-bit mode, a byte 0x40–0x4F directly before the opcode is a REX prefix. Its W bit (bit 3) never changes the width, so no push in 64-bit mode is 4 bytes wide. A 0x66 must come before the REX prefix.
- R3: Opcode 0x6A pushes the following byte, sign-extended to the operand width.
- R4: Opcode 0x68 pushes a little-endian immediate. The immediate is 2 bytes when the width is 2, and 4 bytes otherwise; in 64-bit mode the 4-byte immediate is sign-extended to 64 bits.
- R5: Opcodes 0x50–0x57 push general register {REX bit 0, opcode bits 2:0}. The unit drives that value on `rd_idx` with `rd_seg` = 0, and stores the low width bytes of `rd_data`.
- R6: The stack pointer is decremented by the width. Only its low 16 bits take part in 16-bit mode, and only its low 32 bits in 32-bit mode; the upper bits pass through unchanged. `st_addr` equals `sp_new`.
- R7: The store data is right-aligned and zero above the width. `st_be` has its low width bits set: 0x03, 0x0F or 0xFF.
- R8: A segment push reads `rd_idx` with `rd_seg` = 1, using segment codes ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. The one-byte opcodes are 0x06, 0x0E, 0x16 and 0x1E for codes 0 to 3; the two-byte opcodes are 0x0F 0xA0 for FS and 0x0F 0xA8 for GS. The pointer drops by the full width, but only `rd_data[15:0]` is stored, zero-extended, with `st_be` = 0x03.
- R9: The following raise `ill`, leave `sp_new` equal to `sp_in`, and force `st_be`, `st_data` and `ilen` to 0: the one-byte segment opcodes in 64-bit mode, any second byte after 0x0F other than 0xA0 or 0xA8, and any other opcode. FS and GS pushes stay legal in 64-bit mode.
- R10: `ilen` counts the prefixes, the opcode bytes and the immediate bytes.
- R11: When `in_cnt` is smaller than the number of bytes the instruction needs, the unit raises `need_more` instead of a result. `sp_new` then equals `sp_in`, `st_be` is 0, and `ill` is 0.
- R12: `in_ready` is high when `out_valid` is low or `out_ready` is high. An input accepted at a clock edge appears on the outputs after that edge. The outputs hold while `out_valid` is high and `out_ready` is low.
- R13: After synchronous reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction bytes and state are valid |
| in_ready | output | 1 | Unit can accept an input this cycle |
| mode | input | 2 | Processor mode code |
| in_bytes | input | 48 | Instruction bytes, byte 0 in bits 7:0 |
| in_cnt | input | 3 | Number of valid bytes in `in_bytes` |
| sp_in | input | 64 | Current stack pointer |
| rd_idx | output | 4 | Register-file read index |
| rd_seg | output | 1 | Read targets the segment registers |
| rd_data | input | 64 | Register-file read data |
| out_valid | output | 1 | Registered result is valid |
| out_ready | input | 1 | Consumer takes the result |
| sp_new | output | 64 | Updated stack pointer |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Right-aligned store data |
| st_be | output | 8 | Store byte enables |
| ilen | output | 3 | Instruction length in bytes |
| ill | output | 1 | Invalid opcode |
| need_more | output | 1 | Buffer holds too few bytes |

## Verification
The assertions assume that `in_cnt` never exceeds the six-byte buffer while `in_valid` is high. They also assume that `rd_data` answers the `rd_idx`/`rd_seg` request within the same cycle. The bench meets both assumptions: it drives only counts from 0 to 6, and it models the register files as combinational functions of the read index. Each directed scenario changes its inputs only on the falling edge and holds them for a full cycle.

// File: rtl/push_pkg.sv
package push_pkg;
  localparam int XLEN   = 64;
  localparam int XBYTES = XLEN / 8;

  typedef enum logic [1:0] {
    MODE16 = 2'd0,
    MODE32 = 2'd1,
    MODE64 = 2'd2,
    MODERS = 2'd3
  } cpu_mode_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_IMM8 = 3'd1,
    K_IMMF = 3'd2,
    K_REG  = 3'd3,
    K_SEG  = 3'd4
  } push_kind_e;

  function automatic logic [7:0] be_for_width(input logic [3:0] w);
    logic [7:0] r;
    case (w)
      4'd2:    r = 8'h03;
      4'd4:    r = 8'h0F;
      default: r = 8'hFF;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/push_prefix_scan.sv
module push_prefix_scan #(
  parameter int BUF_BYTES = 6,
  parameter int CNT_W     = 3,
  parameter int LW        = CNT_W + 2
) (
  input  logic [1:0]             mode,
  input  logic [8*BUF_BYTES-1:0] in_bytes,
  input  logic [CNT_W-1:0]       in_cnt,
  output logic                   osz_pfx,
  output logic                   rex_b,
  output logic [LW-1:0]          op_pos,
  output logic                   op_present
);
  import push_pkg::*;

  function automatic logic [7:0] pick(input logic [8*BUF_BYTES-1:0] v, input logic [LW-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < BUF_BYTES; i++)
      if (idx == LW'(i)) r = v[8*i +: 8];
    return r;
  endfunction

  logic [LW-1:0] cnt_x;
  logic [LW-1:0] p1;
  logic [7:0]    rex_byte;
  logic          rex_hit;

  always_comb begin
    cnt_x    = LW'(in_cnt);
    osz_pfx  = (cnt_x >= LW'(1)) && (in_bytes[7:0] == 8'h66);
    p1       = LW'(osz_pfx);
    rex_byte = pick(in_bytes, p1);
    rex_hit  = (cpu_mode_e'(mode) == MODE64) && (cnt_x > p1) &&
               ((rex_byte & 8'hF0) == 8'h40);
    rex_b    = rex_hit && ((rex_byte & 8'h01) != 8'h00);
    op_pos   = p1 + LW'(rex_hit);
    op_present = cnt_x > op_pos;
  end
endmodule

// File: rtl/push_op_decode.sv
module push_op_decode #(
  parameter int BUF_BYTES = 6,
  parameter int CNT_W     = 3,
  parameter int LW        = CNT_W + 2
) (
  input  logic [1:0]             mode,
  input  logic [8*BUF_BYTES-1:0] in_bytes,
  input  logic [CNT_W-1:0]       in_cnt,
  input  logic                   osz_pfx,
  input  logic                   rex_b,
  input  logic [LW-1:0]          op_pos,
  input  logic                   op_present,
  output push_pkg::push_kind_e   kind,
  output logic [3:0]             width,
  output logic [63:0]            imm,
  output logic [3:0]             src_idx,
  output logic                   src_seg,
  output logic [CNT_W-1:0]       ilen,
  output logic                   ill,
  output logic                   need
);
  import push_pkg::*;

  function automatic logic [7:0] pick(input logic [8*BUF_BYTES-1:0] v, input logic [LW-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < BUF_BYTES; i++)
      if (idx == LW'(i)) r = v[8*i +: 8];
    return r;
  endfunction

  logic [7:0]    op, b1, b2, b3, b4;
  logic [LW-1:0] need_len;
  logic [LW-1:0] cnt_x;
  logic          bad_op;
  logic          bad_mode;

  always_comb begin
    bad_mode = 1'b0;
    case (cpu_mode_e'(mode))
      MODE16:  width = osz_pfx ? 4'd4 : 4'd2;
      MODE32:  width = osz_pfx ? 4'd2 : 4'd4;
      MODE64:  width = osz_pfx ? 4'd2 : 4'd8;
      default: begin width = 4'd8; bad_mode = 1'b1; end
    endcase
  end

  always_comb begin
    op = pick(in_bytes, op_pos);
    b1 = pick(in_bytes, op_pos + LW'(1));
    b2 = pick(in_bytes, op_pos + LW'(2));
    b3 = pick(in_bytes, op_pos + LW'(3));
    b4 = pick(in_bytes, op_pos + LW'(4));
    cnt_x    = LW'(in_cnt);
    kind     = K_NONE;
    need_len = op_pos + LW'(1);
    imm      = 64'd0;
    src_idx  = 4'd0;
    src_seg  = 1'b0;
    bad_op   = 1'b0;
    case (op)
      8'h6A: begin
        kind     = K_IMM8;
        need_len = op_pos + LW'(2);
        imm      = {{56{b1[7]}}, b1};
      end
      8'h68: begin
        kind = K_IMMF;
        if (width == 4'd2) begin
          need_len = op_pos + LW'(3);
          imm      = {{48{b2[7]}}, b2, b1};
        end else begin
          need_len = op_pos + LW'(5);
          imm      = {{32{b4[7]}}, b4, b3, b2, b1};
        end
      end
      8'h50, 8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 8'h57: begin
        kind    = K_REG;
        src_idx = {rex_b, op[2:0]};
      end
      8'h06, 8'h0E, 8'h16, 8'h1E: begin
        kind    = K_SEG;
        src_seg = 1'b1;
        src_idx = {2'b00, op[4:3]};
        bad_op  = (cpu_mode_e'(mode) == MODE64);
      end
      8'h0F: begin
        need_len = op_pos + LW'(2);
        kind     = K_SEG;
        src_seg  = 1'b1;
        if (b1 == 8'hA0)      src_idx = 4'd4;
        else if (b1 == 8'hA8) src_idx = 4'd5;
        else                  bad_op  = 1'b1;
      end
      default: bad_op = 1'b1;
    endcase
    need = !op_present || (cnt_x < need_len);
    ill  = !need && (bad_op || bad_mode);
    ilen = (need || ill) ? '0 : need_len[CNT_W-1:0];
  end
endmodule

// File: rtl/push_exec.sv
module push_exec (
  input  logic [1:0]           mode,
  input  push_pkg::push_kind_e kind,
  input  logic [3:0]           width,
  input  logic                 ok,
  input  logic [63:0]          imm,
  input  logic [63:0]          rd_data,
  input  logic [63:0]          sp_in,
  output logic [63:0]          sp_next,
  output logic [63:0]          data,
  output logic [7:0]           be
);
  import push_pkg::*;

  logic [63:0] sp_mask, sp_dec, value, dmask;
  logic [7:0]  be_w;

  always_comb begin
    case (cpu_mode_e'(mode))
      MODE16:  sp_mask = 64'h0000_0000_0000_FFFF;
      MODE32:  sp_mask = 64'h0000_0000_FFFF_FFFF;
      default: sp_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    sp_dec  = sp_in - {60'd0, width};
    sp_next = ok ? ((sp_in & ~sp_mask) | (sp_dec & sp_mask)) : sp_in;
    be_w    = be_for_width(width);
  end

  for (genvar g = 0; g < XBYTES; g++) begin : g_dmask
    assign dmask[8*g +: 8] = {8{be_w[g]}};
  end

  always_comb begin
    case (kind)
      K_REG:   value = rd_data;
      K_SEG:   value = {48'd0, rd_data[15:0]};
      default: value = imm;
    endcase
    data = ok ? (value & dmask) : 64'd0;
    be   = !ok ? 8'h00 : ((kind == K_SEG) ? 8'h03 : be_w);
  end
endmodule

// File: rtl/push_unit.sv
module push_unit #(
  parameter int BUF_BYTES = 6,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             mode,
  input  logic [8*BUF_BYTES-1:0] in_bytes,
  input  logic [CNT_W-1:0]       in_cnt,
  input  logic [63:0]            sp_in,
  output logic [3:0]             rd_idx,
  output logic                   rd_seg,
  input  logic [63:0]            rd_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [63:0]            sp_new,
  output logic [63:0]            st_addr,
  output logic [63:0]            st_data,
  output logic [7:0]             st_be,
  output logic [CNT_W-1:0]       ilen,
  output logic                   ill,
  output logic                   need_more
);
  import push_pkg::*;
  localparam int LW = CNT_W + 2;

  logic             osz_pfx, rex_b, op_present;
  logic [LW-1:0]    op_pos;
  push_kind_e       kind;
  logic [3:0]       dec_width;
  logic [63:0]      imm, sp_next, data_c;
  logic [7:0]       be_c;
  logic [CNT_W-1:0] ilen_c;
  logic             ill_c, need_c, accept;

  push_prefix_scan #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .LW(LW)) u_scan (
    .mode(mode), .in_bytes(in_bytes), .in_cnt(in_cnt),
    .osz_pfx(osz_pfx), .rex_b(rex_b), .op_pos(op_pos), .op_present(op_present)
  );

  push_op_decode #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .LW(LW)) u_dec (
    .mode(mode), .in_bytes(in_bytes), .in_cnt(in_cnt), .osz_pfx(osz_pfx),
    .rex_b(rex_b), .op_pos(op_pos), .op_present(op_present),
    .kind(kind), .width(dec_width), .imm(imm), .src_idx(rd_idx),
    .src_seg(rd_seg), .ilen(ilen_c), .ill(ill_c), .need(need_c)
  );

  push_exec u_exec (
    .mode(mode), .kind(kind), .width(dec_width), .ok(!ill_c && !need_c),
    .imm(imm), .rd_data(rd_data), .sp_in(sp_in),
    .sp_next(sp_next), .data(data_c), .be(be_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sp_new    <= '0;
      st_addr   <= '0;
      st_data   <= '0;
      st_be     <= '0;
      ilen      <= '0;
      ill       <= 1'b0;
      need_more <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      sp_new    <= sp_next;
      st_addr   <= sp_next;
      st_data   <= data_c;
      st_be     <= be_c;
      ilen      <= ilen_c;
      ill       <= ill_c;
      need_more <= need_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(sp_new) && $stable(st_data) && $stable(st_be));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && (ill || need_more) |-> st_be == 8'h00 && ilen == '0 && st_data == 64'd0);

  assert_be_shape_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !ill && !need_more |-> st_be[1:0] == 2'b11 &&
      ($countones(st_be) == 2 || $countones(st_be) == 4 || $countones(st_be) == 8));

  assert_one_fault_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(ill && need_more));

  assert_cnt_range_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> int'(in_cnt) <= BUF_BYTES);

  assert_no_dword64_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && mode == 2'd2 |-> dec_width != 4'd4);
endmodule

// File: tb/push_unit_tb.sv
`timescale 1ns/100ps
module push_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'd1;
  logic [47:0] in_bytes = '0;
  logic [2:0]  in_cnt = '0;
  logic [63:0] sp_in = '0;
  logic [3:0]  rd_idx;
  logic        rd_seg;
  logic [63:0] rd_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] sp_new, st_addr, st_data;
  logic [7:0]  st_be;
  logic [2:0]  ilen;
  logic        ill, need_more;

  int checks = 0;
  int failures = 0;

  localparam logic [63:0] S0 = 64'h0000_7FFF_0000_1000;

  always #2.5 clk = ~clk;

  assign rd_data = rd_seg ? {48'hDEAD_BEEF_CAFE, 16'h1230 + {12'd0, rd_idx}}
                          : 64'h8877_6655_4433_2200 + {60'd0, rd_idx};

  push_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .in_bytes(in_bytes), .in_cnt(in_cnt), .sp_in(sp_in),
    .rd_idx(rd_idx), .rd_seg(rd_seg), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .sp_new(sp_new),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .ilen(ilen),
    .ill(ill), .need_more(need_more)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [47:0] b, input logic [2:0] n, input logic [63:0] sp);
    @(negedge clk);
    mode = m; in_bytes = b; in_cnt = n; sp_in = sp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] sp, input logic [63:0] d,
                           input logic [7:0] be, input logic [2:0] len);
    chk(tag, "out_valid", {63'd0, out_valid}, 64'd1);
    chk(tag, "sp_new", sp_new, sp);
    chk(tag, "st_addr", st_addr, sp);
    chk(tag, "st_data", st_data, d);
    chk(tag, "st_be", {56'd0, st_be}, {56'd0, be});
    chk(tag, "ilen R10", {61'd0, ilen}, {61'd0, len});
    chk(tag, "faults", {62'd0, ill, need_more}, 64'd0);
  endtask

  task automatic expect_fault(input string tag, input logic [63:0] sp, input logic e_ill, input logic e_need);
    chk(tag, "sp_new", sp_new, sp);
    chk(tag, "st_be", {56'd0, st_be}, 64'd0);
    chk(tag, "ilen", {61'd0, ilen}, 64'd0);
    chk(tag, "ill", {63'd0, ill}, {63'd0, e_ill});
    chk(tag, "need_more", {63'd0, need_more}, {63'd0, e_need});
  endtask

  task automatic t_reset();
    chk("R13", "out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12", "in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_natural_width();
    issue(2'd0, 48'h0000_0000_FF6A, 3'd2, S0);
    expect_ok("R1 m16", 64'h0000_7FFF_0000_0FFE, 64'hFFFF, 8'h03, 3'd2);
    issue(2'd1, 48'h0000_0000_7B6A, 3'd2, S0);
    expect_ok("R1 m32", 64'h0000_7FFF_0000_0FFC, 64'h7B, 8'h0F, 3'd2);
    issue(2'd3, 48'h0000_0000_016A, 3'd2, S0);
    expect_fault("R1 reserved", S0, 1'b1, 1'b0);
  endtask

  task automatic t_prefix();
    issue(2'd0, 48'h0000_00FF_6A66, 3'd3, S0);
    expect_ok("R2 m16+66", 64'h0000_7FFF_0000_0FFC, 64'hFFFF_FFFF, 8'h0F, 3'd3);
    issue(2'd2, 48'h1234_5678_6848, 3'd6, S0);
    expect_ok("R2 rexw", 64'h0000_7FFF_0000_0FF8, 64'h1234_5678, 8'hFF, 3'd6);
    issue(2'd2, 48'h0000_0050_4866, 3'd3, S0);
    expect_ok("R2 66+rexw", 64'h0000_7FFF_0000_0FFE, 64'h2200, 8'h03, 3'd3);
    issue(2'd2, 48'h0000_0000_5366, 3'd2, S0);
    expect_ok("R2 R6 m64 word", 64'h0000_7FFF_0000_0FFE, 64'h2203, 8'h03, 3'd2);
  endtask

  task automatic t_imm8();
    issue(2'd2, 48'h0000_0000_806A, 3'd2, S0);
    expect_ok("R3 m64", 64'h0000_7FFF_0000_0FF8, 64'hFFFF_FFFF_FFFF_FF80, 8'hFF, 3'd2);
  endtask

  task automatic t_immfull();
    issue(2'd1, 48'h0000_1234_6866, 3'd4, S0);
    expect_ok("R4 imm16", 64'h0000_7FFF_0000_0FFE, 64'h1234, 8'h03, 3'd4);
    issue(2'd2, 48'h0080_0000_0068, 3'd5, S0);
    expect_ok("R4 sext64", 64'h0000_7FFF_0000_0FF8, 64'hFFFF_FFFF_8000_0000, 8'hFF, 3'd5);
  endtask

  task automatic t_reg();
    issue(2'd2, 48'h0000_0000_5441, 3'd2, S0);
    expect_ok("R5 r12", 64'h0000_7FFF_0000_0FF8, 64'h8877_6655_4433_220C, 8'hFF, 3'd2);
    issue(2'd1, 48'h0000_0000_0055, 3'd1, S0);
    expect_ok("R5 R7 m32", 64'h0000_7FFF_0000_0FFC, 64'h4433_2205, 8'h0F, 3'd1);
  endtask

  task automatic t_sp_wrap();
    issue(2'd0, 48'h0000_0000_016A, 3'd2, 64'h1234_0000_0000_0000);
    expect_ok("R6 wrap16", 64'h1234_0000_0000_FFFE, 64'h0001, 8'h03, 3'd2);
    issue(2'd1, 48'h0000_0000_016A, 3'd2, 64'hABCD_0000_0000_0002);
    expect_ok("R6 wrap32", 64'hABCD_0000_FFFF_FFFE, 64'h0001, 8'h0F, 3'd2);
  endtask

  task automatic t_seg();
    issue(2'd1, 48'h0000_0000_001E, 3'd1, S0);
    expect_ok("R8 ds", 64'h0000_7FFF_0000_0FFC, 64'h1233, 8'h03, 3'd1);
    issue(2'd2, 48'h0000_0000_A80F, 3'd2, S0);
    expect_ok("R8 R9 gs64", 64'h0000_7FFF_0000_0FF8, 64'h1235, 8'h03, 3'd2);
  endtask

  task automatic t_illegal();
    issue(2'd2, 48'h0000_0000_0006, 3'd1, S0);
    expect_fault("R9 es64", S0, 1'b1, 1'b0);
    issue(2'd2, 48'h0000_0000_A10F, 3'd2, S0);
    expect_fault("R9 0f-a1", S0, 1'b1, 1'b0);
    issue(2'd1, 48'h0000_0000_5441, 3'd2, S0);
    expect_fault("R9 no-rex32", S0, 1'b1, 1'b0);
    chk("R9", "st_data", st_data, 64'd0);
  endtask

  task automatic t_short();
    issue(2'd1, 48'h0000_2211_0068, 3'd3, S0);
    expect_fault("R11 imm", S0, 1'b0, 1'b1);
    issue(2'd1, 48'h0000_0000_0000, 3'd0, S0);
    expect_fault("R11 empty", S0, 1'b0, 1'b1);
    issue(2'd2, 48'h0000_0000_0F41, 3'd2, S0);
    expect_fault("R11 0f", S0, 1'b0, 1'b1);
  endtask

  task automatic t_handshake();
    @(negedge clk);
    out_ready = 1'b0;
    issue(2'd1, 48'h0000_0000_016A, 3'd2, S0);
    chk("R12", "out_valid", {63'd0, out_valid}, 64'd1);
    chk("R12", "in_ready low", {63'd0, in_ready}, 64'd0);
    mode = 2'd1; in_bytes = 48'h0000_0000_026A; in_cnt = 3'd2; in_valid = 1'b1;
    @(negedge clk);
    chk("R12", "held data", st_data, 64'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", "next data", st_data, 64'h2);
    @(negedge clk);
    chk("R12", "drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_natural_width();
    t_prefix();
    t_imm8();
    t_immfull();
    t_reg();
    t_sp_wrap();
    t_seg();
    t_illegal();
    t_short();
    t_handshake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule